// File: doc/BRIEF.md
# Counter-Race Oscillator Band Calibrator

This block chooses the coarse band code of an oscillator whose tuning range is split into overlapping bands. The oscillator's divided output comes back as a feedback clock. Each calibration step is a race between two counters that start from zero together. One counter runs on the reference clock and the other runs on the feedback clock. The counter that reaches a hit threshold first belongs to the faster clock. A race ends when the reference counter passes a second, larger threshold. The outcome of each race sets one bit of a successive-approximation search over the band code.

The band code starts at mid-scale. It then moves up or down by a halving weight after each race until every weight has been used. The final code is then frozen and a done flag is raised. Every decision is made in the reference clock domain. The one feedback-side result, whether the feedback counter has crossed the hit threshold, reaches that domain through a synchronizer chain. The command that clears the feedback counter is synchronized into the feedback domain in the same way. Driving the active-low reset low at any moment throws away the search in progress. Releasing it starts a new calibration.

Top module: `bandcal_top`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `bandCode` is mid-scale (only the MSB set, 128 for 8 bits) and `calDone` is 0. Pulling `rstN` low partway through a calibration returns these values at once.
- R2: Each race starts with both counters at zero. It ends when the registered reference count goes above `END_VAL`. A race never runs longer than about `END_VAL` reference cycles.
- R3: The winner of a race is the first counter whose registered count is at or above `HIT_VAL`, as seen in the reference domain. When the feedback counter wins, the band code goes down by the current weight. When the reference counter wins, it goes up by the current weight. With the feedback clock left to follow the code, the search settles near the code where the two frequencies match.
- R4: The weights of the successive races are 2^(BAND_W-2) down to 1, one race per weight (64, 32, 16, 8, 4, 2, 1 for 8 bits). The band code changes only when a race ends.
- R5: `calDone` rises in the same cycle as the last band update. From then until the next reset, `bandCode` holds its value and no race runs, whatever the feedback clock does.
- R6: The winner record is cleared before each race begins. Each update therefore reflects only the race that just ended, even when the winner alternates from race to race.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock; all decisions are made in this domain |
| fbClk | input | 1 | Divided oscillator feedback clock |
| rstN | input | 1 | Active-low asynchronous reset; releasing it starts a calibration |
| bandCode | output | BAND_W | Band selection code driven to the oscillator |
| calDone | output | 1 | High once the search has finished |

## Verification
The bench builds the block with an 8-bit counter, a hit threshold of 100 and an end threshold of 110. This keeps each race near 135 reference cycles, so one run can hold many complete calibrations. With these values a feedback clock five times faster than the reference drives the feedback counter to its ceiling within a race, so the saturation path is exercised. Fixed fast and slow feedback clocks that switch between races produce exact expected codes for any win/lose pattern. A loop mode makes the feedback period a function of the code, which tests convergence, and a mid-run reset tests restart.

// File: rtl/bandcal_pkg.sv
`timescale 1ns/1ps
package bandcal_pkg;

  // strobes from the search control into the race datapath
  typedef struct packed {
    logic clearRace;   // hold both counters and the winner record at zero
    logic armCapture;  // race in progress, winner may be recorded
  } ctlStrobeT;

  // status from the race datapath back to the control
  typedef struct packed {
    logic raceEnd;     // registered: reference count has passed the end threshold
    logic fbWon;       // registered: feedback counter crossed the hit threshold first
  } raceStatT;

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_RUN   = 2'd1,
    ST_DONE  = 2'd2
  } calStateT;

endpackage

// File: rtl/bandcal_sync.sv
`timescale 1ns/1ps
module bandcal_sync #(
  parameter int   STAGES = 2,
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_LVL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/bandcal_race.sv
`timescale 1ns/1ps
module bandcal_race
  import bandcal_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int HIT_VAL     = 230,
  parameter int END_VAL     = 240,
  parameter int SYNC_STAGES = 2
) (
  input  logic      refClk,
  input  logic      fbClk,
  input  logic      rstN,
  input  ctlStrobeT ctl,
  output raceStatT  stat
);

  localparam logic [CNT_W-1:0] HIT_C = CNT_W'(HIT_VAL);
  localparam logic [CNT_W-1:0] END_C = CNT_W'(END_VAL);
  localparam logic [CNT_W-1:0] MAX_C = {CNT_W{1'b1}};

  // ---------------- reference side ----------------
  logic [CNT_W-1:0] refCnt;
  logic             refHitR;
  logic             refOverR;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)               refCnt <= '0;
    else if (ctl.clearRace)  refCnt <= '0;
    else if (refCnt != MAX_C) refCnt <= refCnt + 1'b1;
  end

  // comparator results are registered before use
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      refHitR  <= 1'b0;
      refOverR <= 1'b0;
    end else begin
      refHitR  <= (refCnt >= HIT_C);
      refOverR <= (refCnt > END_C);
    end
  end

  // ---------------- feedback side ----------------
  logic             fbClearS;
  logic [CNT_W-1:0] fbCnt;
  logic             fbHitR;

  bandcal_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_clrSync (
    .clk (fbClk),
    .rstN(rstN),
    .d   (ctl.clearRace),
    .q   (fbClearS)
  );

  // saturates at its ceiling so a fast feedback clock cannot wrap it
  always_ff @(posedge fbClk or negedge rstN) begin
    if (!rstN)               fbCnt <= '0;
    else if (fbClearS)       fbCnt <= '0;
    else if (fbCnt != MAX_C) fbCnt <= fbCnt + 1'b1;
  end

  always_ff @(posedge fbClk or negedge rstN) begin
    if (!rstN) fbHitR <= 1'b0;
    else       fbHitR <= (fbCnt >= HIT_C);
  end

  // ---------------- back into the reference domain ----------------
  logic fbHitS;

  bandcal_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b0)) u_hitSync (
    .clk (refClk),
    .rstN(rstN),
    .d   (fbHitR),
    .q   (fbHitS)
  );

  // winner record: first cycle in which exactly one side has crossed
  logic oneCrossed;
  logic winValid;
  logic fbWon;

  assign oneCrossed = refHitR ^ fbHitS;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      winValid <= 1'b0;
      fbWon    <= 1'b0;
    end else if (ctl.clearRace) begin
      winValid <= 1'b0;
      fbWon    <= 1'b0;
    end else if (ctl.armCapture && !winValid && oneCrossed) begin
      winValid <= 1'b1;
      fbWon    <= fbHitS;
    end
  end

  assign stat.raceEnd = refOverR;
  assign stat.fbWon   = fbWon;

endmodule

// File: rtl/bandcal_search.sv
`timescale 1ns/1ps
module bandcal_search
  import bandcal_pkg::*;
#(
  parameter int BAND_W       = 8,
  parameter int CLEAR_CYCLES = 16
) (
  input  logic              refClk,
  input  logic              rstN,
  input  raceStatT          stat,
  output ctlStrobeT         ctl,
  output logic [BAND_W-1:0] bandCode,
  output logic              calDone
);

  localparam int               NUM_RACES = BAND_W - 1;
  localparam int               RACE_W    = $clog2(NUM_RACES + 1);
  localparam int               CLR_W     = $clog2(CLEAR_CYCLES + 1);
  localparam logic [BAND_W-1:0] MID_C    = BAND_W'(1) << (BAND_W - 1);
  localparam logic [BAND_W-1:0] W0_C     = BAND_W'(1) << (BAND_W - 2);
  localparam logic [CLR_W-1:0]  CLR_LAST = CLR_W'(CLEAR_CYCLES - 1);
  localparam logic [RACE_W-1:0] RACE_LAST = RACE_W'(NUM_RACES - 1);

  calStateT          state;
  logic [CLR_W-1:0]  clrCnt;
  logic [RACE_W-1:0] raceNum;
  logic [BAND_W-1:0] weight;
  logic              decide;

  assign decide = (state == ST_RUN) && stat.raceEnd;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_CLEAR;
      clrCnt   <= '0;
      raceNum  <= '0;
      weight   <= W0_C;
      bandCode <= MID_C;
    end else begin
      unique case (state)
        ST_CLEAR: begin
          if (clrCnt == CLR_LAST) begin
            state  <= ST_RUN;
            clrCnt <= '0;
          end else begin
            clrCnt <= clrCnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (decide) begin
            if (stat.fbWon) bandCode <= bandCode - weight;
            else            bandCode <= bandCode + weight;
            weight  <= weight >> 1;
            raceNum <= raceNum + 1'b1;
            state   <= (raceNum == RACE_LAST) ? ST_DONE : ST_CLEAR;
          end
        end
        ST_DONE: state <= ST_DONE;
        default: state <= ST_CLEAR;
      endcase
    end
  end

  assign ctl.clearRace  = (state != ST_RUN);
  assign ctl.armCapture = (state == ST_RUN);
  assign calDone        = (state == ST_DONE);

endmodule

// File: rtl/bandcal_top.sv
`timescale 1ns/1ps
module bandcal_top
  import bandcal_pkg::*;
#(
  parameter int BAND_W       = 8,
  parameter int CNT_W        = 10,
  parameter int HIT_VAL      = 230,
  parameter int END_VAL      = 240,
  parameter int SYNC_STAGES  = 2,
  parameter int CLEAR_CYCLES = 16
) (
  input  logic              refClk,
  input  logic              fbClk,
  input  logic              rstN,
  output logic [BAND_W-1:0] bandCode,
  output logic              calDone
);

  ctlStrobeT ctl;
  raceStatT  stat;

  bandcal_race #(
    .CNT_W      (CNT_W),
    .HIT_VAL    (HIT_VAL),
    .END_VAL    (END_VAL),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_race (
    .refClk(refClk),
    .fbClk (fbClk),
    .rstN  (rstN),
    .ctl   (ctl),
    .stat  (stat)
  );

  bandcal_search #(
    .BAND_W      (BAND_W),
    .CLEAR_CYCLES(CLEAR_CYCLES)
  ) u_search (
    .refClk  (refClk),
    .rstN    (rstN),
    .stat    (stat),
    .ctl     (ctl),
    .bandCode(bandCode),
    .calDone (calDone)
  );

endmodule

// File: rtl/bandcal_chk.sv
`timescale 1ns/1ps
module bandcal_chk
  import bandcal_pkg::*;
#(
  parameter int BAND_W  = 8,
  parameter int END_VAL = 240
) (
  input logic              refClk,
  input logic              rstN,
  input logic [BAND_W-1:0] bandCode,
  input logic              calDone,
  input ctlStrobeT         ctl,
  input raceStatT          stat
);

  localparam logic [BAND_W-1:0] MID_C = BAND_W'(1) << (BAND_W - 1);
  localparam int RUN_LIM = END_VAL + 4;

  logic              seenClk;
  logic [BAND_W-1:0] prevBand;
  logic              prevEnd;
  logic [31:0]       runLen;
  logic [BAND_W-1:0] dUp;
  logic [BAND_W-1:0] dDown;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      seenClk  <= 1'b0;
      prevBand <= MID_C;
      prevEnd  <= 1'b0;
      runLen   <= '0;
    end else begin
      seenClk  <= 1'b1;
      prevBand <= bandCode;
      prevEnd  <= stat.raceEnd && ctl.armCapture;
      runLen   <= ctl.armCapture ? runLen + 1 : '0;
    end
  end

  assign dUp   = bandCode - prevBand;
  assign dDown = prevBand - bandCode;

  // R1: mid-scale code and no done flag right after reset
  a_r1_start_state: assert property (@(posedge refClk) disable iff (!rstN)
    !seenClk |-> (bandCode == MID_C && !calDone));

  // R2: a race cannot outlast the end threshold
  a_r2_race_bounded: assert property (@(posedge refClk) disable iff (!rstN)
    runLen <= RUN_LIM);

  // R3: every update is a single binary weight up or down
  a_r3_pow2_step: assert property (@(posedge refClk) disable iff (!rstN)
    (bandCode != prevBand) |-> ($countones(dUp) == 1 || $countones(dDown) == 1));

  // R4: code moves only right after a race ended
  a_r4_step_at_end: assert property (@(posedge refClk) disable iff (!rstN)
    (bandCode != prevBand) |-> prevEnd);

  // R5: once done, code and flag hold
  a_r5_done_hold: assert property (@(posedge refClk) disable iff (!rstN)
    calDone |=> (calDone && $stable(bandCode)));

  // R6: winner record cleared while a race is being set up
  a_r6_winner_cleared: assert property (@(posedge refClk) disable iff (!rstN)
    ctl.clearRace |=> !stat.fbWon);

endmodule

bind bandcal_top bandcal_chk #(
  .BAND_W (BAND_W),
  .END_VAL(END_VAL)
) u_chk (
  .refClk  (refClk),
  .rstN    (rstN),
  .bandCode(bandCode),
  .calDone (calDone),
  .ctl     (ctl),
  .stat    (stat)
);

// File: tb/sim_bandcal_top.sv
`timescale 1ns/1ps
module sim_bandcal_top;

  localparam int BW = 8;

  logic          refClk = 1'b0;
  logic          fbClk  = 1'b0;
  logic          rstN   = 1'b0;
  logic [BW-1:0] bandCode;
  logic          calDone;

  int  nTests = 0;
  int  nFail  = 0;
  bit  finished = 0;
  int  fbMode = 0;  // 0 fast, 1 slow, 2 follows code

  bandcal_top #(
    .BAND_W(BW), .CNT_W(8), .HIT_VAL(100), .END_VAL(110),
    .SYNC_STAGES(2), .CLEAR_CYCLES(24)
  ) u0 (
    .refClk(refClk), .fbClk(fbClk), .rstN(rstN),
    .bandCode(bandCode), .calDone(calDone)
  );

  always #10 refClk = ~refClk;  // 50 MHz

  realtime fbHalf;
  always begin
    case (fbMode)
      0:       fbHalf = 2.0;   // 250 MHz, feedback wins
      1:       fbHalf = 20.0;  // 25 MHz, reference wins
      default: fbHalf = 10.0 * 256.0 / (real'(bandCode) + 96.0);
    endcase
    #(fbHalf) fbClk = ~fbClk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge refClk);
    rstN = 1'b0;
    repeat (4) @(negedge refClk);
    check(bandCode == 8'd128, "R1 reset band", bandCode, 128);
    check(calDone == 1'b0, "R1 reset done", calDone, 0);
    rstN = 1'b1;
    @(negedge refClk);
    check(bandCode == 8'd128, "R1 first cycle band", bandCode, 128);
  endtask

  task automatic waitChange(input logic [BW-1:0] prev, output bit ok);
    ok = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge refClk);
      if (bandCode != prev) begin ok = 1; break; end
    end
  endtask

  // bit i of pat set: feedback fast (wins) during race i
  task automatic runPattern(input logic [6:0] pat, input string tag);
    int exp = 128;
    int w = 64;
    bit ok;
    fbMode = pat[0] ? 0 : 1;
    doReset();
    for (int i = 0; i < 7; i++) begin
      waitChange(BW'(exp), ok);
      check(ok, {tag, " R2 race ended"}, i, 1);
      exp = pat[i] ? exp - w : exp + w;
      w = w / 2;
      check(bandCode == BW'(exp), {tag, " R3 R4 step value"}, bandCode, exp);
      check(calDone == (i == 6), {tag, " R5 done timing"}, calDone, (i == 6));
      if (i < 6) fbMode = pat[i+1] ? 0 : 1;
    end
    fbMode = pat[6] ? 1 : 0;
    repeat (1200) @(negedge refClk);
    check(bandCode == BW'(exp) && calDone, {tag, " R5 hold after done"}, bandCode, exp);
  endtask

  task automatic testMidReset();
    bit ok;
    logic [BW-1:0] prev;
    fbMode = 0;
    doReset();
    prev = 8'd128;
    for (int i = 0; i < 3; i++) begin
      waitChange(prev, ok);
      prev = bandCode;
    end
    check(bandCode == 8'd16, "R1 before mid reset", bandCode, 16);
    @(negedge refClk);
    rstN = 1'b0;
    #1;
    check(bandCode == 8'd128 && !calDone, "R1 mid-run reset", bandCode, 128);
    runPattern(7'b0000000, "after-reset");
  endtask

  task automatic testLoop();
    fbMode = 2;
    doReset();
    for (int k = 0; k < 4000 && !calDone; k++) @(negedge refClk);
    check(calDone, "R3 loop done", calDone, 1);
    check(bandCode >= 8'd150 && bandCode <= 8'd186, "R3 loop converged", bandCode, 168);
  endtask

  initial begin
    repeat (150000) @(posedge refClk);
    if (!finished) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    runPattern(7'b1111111, "all-fb");
    runPattern(7'b0000000, "all-ref");
    runPattern(7'b1010101, "R6 alternate");
    runPattern(7'b0101010, "R6 alternate-inv");
    runPattern(7'b0110010, "mixed");
    testMidReset();
    testLoop();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule